// File: doc/BRIEF.md
# Overload Fault Timer and Protection Sequencer

This block is the supervisor of a quasi-resonant flyback controller. It decides, cycle by cycle, whether the power switch may be pulsed. It also drives the enable of the high-voltage startup current source that charges the supply capacitor, and it asks the modulator for a soft-start whenever switching resumes. Every input is a digital flag from an analog comparator: overload, the supply-rail level crossings, bulk-voltage status, external disable and latch requests, and thermal shutdown.

Overload is timed independently of the supply. A continuous overload of `FAULT_CYCLES` clocks puts the block into protection mode. In protection mode the startup source hysteresis moves down to the low latch level. The output is released only on the `RECHARGES`-th recharge of the supply to the start level.

Recoverable stop conditions gate the output without changing state. An external latch request parks the block until the supply collapses below the release level. All flags pass through a synchronizer of `SYNC_STAGES` flops before use.

Top module: `prot_seq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `sw_en` = 0, `soft_start` = 0 and `hv_src_en` = 1.
- R2: After reset the block waits with `hv_src_en` = 1 and `sw_en` = 0 until `vcc_at_start` is seen. It then enables switching and drops `hv_src_en`.
- R3: Protection is entered only when `ovld_req` has been seen high on `FAULT_CYCLES` consecutive clocks. Any low cycle resets the count, so a shorter burst has no effect on `sw_en`.
- R4: In protection `sw_en` = 0. `hv_src_en` is 0 on entry, is set when `vcc_le_latch` is seen, and is cleared when `vcc_at_start` is seen.
- R5: In protection an arrival is the sighting of `vcc_at_start` while `hv_src_en` = 1. The first arrival keeps the output off. The `RECHARGES`-th arrival (default 2) returns to normal switching with a soft-start.
- R6: In normal operation, `vcc_le_uv` seen while `hv_src_en` = 1 enters protection.
- R7: Any of `vcc_ovp`, `bulk_ok` = 0, `ext_disable` or `therm_hot` forces `sw_en` = 0. When all of them clear, switching resumes with a soft-start.
- R8: `ext_latch` enters the latched state. There `sw_en` stays 0 however many times the supply recharges, and `hv_src_en` cycles between `vcc_le_latch` and `vcc_at_start`. Only `vcc_lt_release` (with `ext_latch` low) leaves the state, returning to the startup wait with `hv_src_en` = 1.
- R9: `ext_latch` overrides every other state. Protection holds `sw_en` at 0 even when all recoverable stop conditions are clear.
- R10: `soft_start` is a one-cycle pulse, high exactly in the first cycle of each rise of `sw_en`.
- R11: In normal operation `hv_src_en` is set when `vcc_le_min` is seen and cleared when `vcc_at_start` is seen.
- R12: A flag change driven before clock edge k appears on the outputs after edge k+`SYNC_STAGES`, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovld_req | input | 1 | Feedback demands maximum power |
| vcc_at_start | input | 1 | Supply at or above the start level |
| vcc_le_min | input | 1 | Supply at or below the normal minimum level |
| vcc_le_uv | input | 1 | Supply at or below the charging undervoltage level |
| vcc_le_latch | input | 1 | Supply at or below the low latch level |
| vcc_lt_release | input | 1 | Supply below the latch release level |
| vcc_ovp | input | 1 | Supply overvoltage |
| bulk_ok | input | 1 | Bulk voltage above the brown-out level |
| ext_disable | input | 1 | External recoverable disable |
| ext_latch | input | 1 | External permanent latch request |
| therm_hot | input | 1 | Thermal shutdown |
| sw_en | output | 1 | Switching allowed |
| hv_src_en | output | 1 | High-voltage startup source on |
| soft_start | output | 1 | One-cycle soft-start request |

## Verification
The assertions assume the supply flags describe one physical voltage. In particular, `vcc_at_start` is never high together with any of the low-level flags, and each flag is held for at least the synchronizer depth.

The stimulus keeps to this by moving the supply through its levels one flag at a time, always dropping one flag before raising the next. It waits past the synchronizer latency after every change before sampling.

The overload sweep steps burst lengths across the timer limit and leaves a gap between bursts, so each burst starts from a cleared count.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PROT  = 2'd2,
        ST_LATCH = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ovld;
        logic at_start;
        logic le_min;
        logic le_uv;
        logic le_latch;
        logic lt_release;
        logic ovp;
        logic bulk_ok;
        logic ext_dis;
        logic ext_latch;
        logic hot;
    } flag_set_t;

    localparam int FLAG_W = $bits(flag_set_t);

    // Recoverable conditions that gate the output without a state change.
    function automatic logic run_blocked(input flag_set_t f);
        return f.ovp | ~f.bulk_ok | f.ext_dis | f.hot;
    endfunction

    // Source hysteresis: off request wins over on request.
    function automatic logic hv_step(input logic cur, input logic on_req, input logic off_req);
        if (off_req)     return 1'b0;
        else if (on_req) return 1'b1;
        else             return cur;
    endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fault_timer.sv
module fault_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic ovld,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable || !ovld) cnt <= '0;
        else if (cnt != LAST)        cnt <= cnt + 1'b1;
    end

    assign expired = enable & ovld & (cnt == LAST);

    always_comb begin
        if (!rst) p_cnt_bound_r3: assert (cnt <= LAST);
    end

    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !(enable && ovld) |=> (cnt == '0));
endmodule

// File: rtl/prot_fsm.sv
module prot_fsm
    import prot_seq_pkg::*;
#(
    parameter int RECHARGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  flag_set_t f,
    input  logic      expired,
    output logic      timer_en,
    output logic      sw_en,
    output logic      hv_en,
    output logic      ss_pulse
);
    localparam int AW = (RECHARGES > 1) ? $clog2(RECHARGES) : 1;
    localparam logic [AW-1:0] LAST_ARR = AW'(RECHARGES - 1);

    seq_state_e state, nxt;
    logic       hv_q, hv_d;
    logic       sw_q, sw_d;
    logic       ss_q;
    logic [AW-1:0] arr_q, arr_d;

    always_comb begin
        nxt   = state;
        hv_d  = hv_q;
        arr_d = arr_q;
        if (f.ext_latch && state != ST_LATCH) begin
            nxt  = ST_LATCH;
            hv_d = 1'b0;
        end else begin
            unique case (state)
                ST_BOOT: begin
                    hv_d = 1'b1;
                    if (f.at_start) begin
                        nxt  = ST_RUN;
                        hv_d = 1'b0;
                    end
                end
                ST_RUN: begin
                    if (expired || (hv_q && f.le_uv)) begin
                        nxt   = ST_PROT;
                        hv_d  = 1'b0;
                        arr_d = '0;
                    end else begin
                        hv_d = hv_step(hv_q, f.le_min, f.at_start);
                    end
                end
                ST_PROT: begin
                    hv_d = hv_step(hv_q, f.le_latch, f.at_start);
                    if (hv_q && f.at_start) begin
                        if (arr_q == LAST_ARR) begin
                            nxt   = ST_RUN;
                            arr_d = '0;
                        end else begin
                            arr_d = arr_q + 1'b1;
                        end
                    end
                end
                ST_LATCH: begin
                    if (f.lt_release && !f.ext_latch) begin
                        nxt  = ST_BOOT;
                        hv_d = 1'b1;
                    end else begin
                        hv_d = hv_step(hv_q, f.le_latch, f.at_start);
                    end
                end
                default: nxt = ST_BOOT;
            endcase
        end
        sw_d = (nxt == ST_RUN) && !run_blocked(f);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_BOOT;
            hv_q  <= 1'b1;
            sw_q  <= 1'b0;
            ss_q  <= 1'b0;
            arr_q <= '0;
        end else begin
            state <= nxt;
            hv_q  <= hv_d;
            sw_q  <= sw_d;
            ss_q  <= sw_d & ~sw_q;
            arr_q <= arr_d;
        end
    end

    assign timer_en = (state == ST_RUN);
    assign sw_en    = sw_q;
    assign hv_en    = hv_q;
    assign ss_pulse = ss_q;

    p_ss_edge_r10: assert property (@(posedge clk) disable iff (rst)
        ss_q |-> (sw_q && !$past(sw_q)));
    p_ss_once_r10: assert property (@(posedge clk) disable iff (rst)
        ss_q |=> !ss_q);
    p_stop_r7: assert property (@(posedge clk) disable iff (rst)
        run_blocked(f) |=> !sw_q);
    p_idle_states_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |-> (!sw_q && !ss_q));
    p_latch_pri_r9: assert property (@(posedge clk) disable iff (rst)
        f.ext_latch |=> (state == ST_LATCH));
    p_prot_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROT) |=> (state != ST_RUN || $past(hv_q && f.at_start)));
endmodule

// File: rtl/prot_seq_ctrl.sv
module prot_seq_ctrl
    import prot_seq_pkg::*;
#(
    parameter int FAULT_CYCLES = 4000000,
    parameter int RECHARGES    = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ovld_req,
    input  logic vcc_at_start,
    input  logic vcc_le_min,
    input  logic vcc_le_uv,
    input  logic vcc_le_latch,
    input  logic vcc_lt_release,
    input  logic vcc_ovp,
    input  logic bulk_ok,
    input  logic ext_disable,
    input  logic ext_latch,
    input  logic therm_hot,
    output logic sw_en,
    output logic hv_src_en,
    output logic soft_start
);
    flag_set_t          raw;
    logic [FLAG_W-1:0]  synced;
    flag_set_t          flags;
    logic               timer_en;
    logic               expired;

    always_comb begin
        raw.ovld       = ovld_req;
        raw.at_start   = vcc_at_start;
        raw.le_min     = vcc_le_min;
        raw.le_uv      = vcc_le_uv;
        raw.le_latch   = vcc_le_latch;
        raw.lt_release = vcc_lt_release;
        raw.ovp        = vcc_ovp;
        raw.bulk_ok    = bulk_ok;
        raw.ext_dis    = ext_disable;
        raw.ext_latch  = ext_latch;
        raw.hot        = therm_hot;
    end

    flag_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    assign flags = flag_set_t'(synced);

    fault_timer #(.LIMIT(FAULT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .enable  (timer_en),
        .ovld    (flags.ovld),
        .expired (expired)
    );

    prot_fsm #(.RECHARGES(RECHARGES)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .f        (flags),
        .expired  (expired),
        .timer_en (timer_en),
        .sw_en    (sw_en),
        .hv_en    (hv_src_en),
        .ss_pulse (soft_start)
    );
endmodule

// File: tb/prot_seq_ctrl_tb.sv
module prot_seq_ctrl_tb;
    localparam int LIM = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ovld_req = 0, vcc_at_start = 0, vcc_le_min = 0, vcc_le_uv = 0;
    logic vcc_le_latch = 0, vcc_lt_release = 0, vcc_ovp = 0, bulk_ok = 1;
    logic ext_disable = 0, ext_latch = 0, therm_hot = 0;
    logic sw_en, hv_src_en, soft_start;
    int   errors = 0;
    int   checks = 0;

    always #10 clk = ~clk;

    prot_seq_ctrl #(.FAULT_CYCLES(LIM), .RECHARGES(2), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .ovld_req(ovld_req), .vcc_at_start(vcc_at_start),
        .vcc_le_min(vcc_le_min), .vcc_le_uv(vcc_le_uv), .vcc_le_latch(vcc_le_latch),
        .vcc_lt_release(vcc_lt_release), .vcc_ovp(vcc_ovp), .bulk_ok(bulk_ok),
        .ext_disable(ext_disable), .ext_latch(ext_latch), .therm_hot(therm_hot),
        .sw_en(sw_en), .hv_src_en(hv_src_en), .soft_start(soft_start)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic set_stop(input int idx, input logic on);
        case (idx)
            0: vcc_ovp     = on;
            1: bulk_ok     = ~on;
            2: ext_disable = on;
            default: therm_hot = on;
        endcase
    endtask

    // Two supply recharges out of protection (R4, R5).
    task automatic recover();
        vcc_le_latch = 1; tick(3);
        chk("R4 source on at latch level", hv_src_en, 1'b1);
        vcc_le_latch = 0; vcc_at_start = 1; tick(3);
        chk("R4 source off at start level", hv_src_en, 1'b0);
        chk("R5 first arrival keeps output off", sw_en, 1'b0);
        vcc_at_start = 0; vcc_le_latch = 1; tick(3);
        chk("R4 source on again", hv_src_en, 1'b1);
        vcc_le_latch = 0; vcc_at_start = 1; tick(3);
        chk("R5 second arrival releases output", sw_en, 1'b1);
        chk("R5 soft-start on release", soft_start, 1'b1);
        chk("R4 source off after release", hv_src_en, 1'b0);
        vcc_at_start = 0; tick(1);
        chk("R10 soft-start lasts one cycle", soft_start, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        chk("R1 sw_en in reset", sw_en, 1'b0);
        chk("R1 hv_src_en in reset", hv_src_en, 1'b1);
        rst = 0;
        chk("R1 soft_start after reset", soft_start, 1'b0);
        chk("R1 sw_en after reset", sw_en, 1'b0);

        // R2 startup wait
        tick(3);
        chk("R2 waits with source on", hv_src_en, 1'b1);
        chk("R2 waits with output off", sw_en, 1'b0);
        vcc_at_start = 1; tick(3);
        chk("R2 switching after start level", sw_en, 1'b1);
        chk("R10 soft-start on first enable", soft_start, 1'b1);
        chk("R2 source off after start", hv_src_en, 1'b0);
        vcc_at_start = 0; tick(1);
        chk("R10 pulse ends", soft_start, 1'b0);

        // R11 normal self-supply hysteresis
        vcc_le_min = 1; tick(3);
        chk("R11 source on at min level", hv_src_en, 1'b1);
        vcc_le_min = 0; tick(3);
        chk("R11 source holds between levels", hv_src_en, 1'b1);
        vcc_at_start = 1; tick(3);
        chk("R11 source off at start level", hv_src_en, 1'b0);
        vcc_at_start = 0; tick(1);

        // R12 synchronizer latency
        ext_disable = 1; tick(2);
        chk("R12 not visible after two edges", sw_en, 1'b1);
        tick(1);
        chk("R12 visible after three edges", sw_en, 1'b0);
        ext_disable = 0; tick(3);
        chk("R7 resume after disable", sw_en, 1'b1);
        tick(1);

        // R7 sweep of recoverable stop conditions
        for (int i = 0; i < 4; i++) begin
            set_stop(i, 1'b1); tick(3);
            chk("R7 stop condition gates output", sw_en, 1'b0);
            chk("R7 no soft-start while stopped", soft_start, 1'b0);
            set_stop(i, 1'b0); tick(3);
            chk("R7 resume when cleared", sw_en, 1'b1);
            chk("R7 soft-start on resume", soft_start, 1'b1);
            tick(1);
            chk("R10 single pulse", soft_start, 1'b0);
        end

        // R3 overload burst lengths around the limit
        for (int len = LIM - 2; len <= LIM + 1; len++) begin
            ovld_req = 1; tick(len);
            ovld_req = 0; tick(4);
            chk("R3 trip iff burst reaches limit", sw_en, (len < LIM));
            if (len >= LIM) begin
                chk("R4 source off on protection entry", hv_src_en, 1'b0);
                recover();
            end
        end

        // R6 undervoltage while charging
        vcc_le_min = 1; tick(3);
        chk("R11 source on", hv_src_en, 1'b1);
        vcc_le_uv = 1; tick(3);
        chk("R6 undervoltage enters protection", sw_en, 1'b0);
        chk("R6 source off in protection", hv_src_en, 1'b0);
        vcc_le_uv = 0; vcc_le_min = 0;
        recover();

        // R9 protection beats recoverable conditions, latch beats protection
        ovld_req = 1; tick(LIM + 3); ovld_req = 0; tick(2);
        chk("R3 held overload trips", sw_en, 1'b0);
        ext_disable = 1; tick(3); ext_disable = 0; tick(3);
        chk("R9 protection holds output off", sw_en, 1'b0);
        ext_latch = 1; tick(3);
        chk("R9 latch overrides protection", sw_en, 1'b0);
        chk("R8 source off on latch entry", hv_src_en, 1'b0);
        ext_latch = 0; tick(3);

        // R8 latch persists across recharges
        for (int k = 0; k < 3; k++) begin
            vcc_le_latch = 1; tick(3);
            chk("R8 source on at latch level", hv_src_en, 1'b1);
            vcc_le_latch = 0; vcc_at_start = 1; tick(3);
            chk("R8 source off at start level", hv_src_en, 1'b0);
            chk("R8 output stays off", sw_en, 1'b0);
            vcc_at_start = 0; tick(1);
        end
        vcc_lt_release = 1; tick(3);
        chk("R8 collapse returns to startup wait", hv_src_en, 1'b1);
        chk("R8 output off after collapse", sw_en, 1'b0);
        vcc_lt_release = 0; vcc_at_start = 1; tick(3);
        chk("R2 start after latch release", sw_en, 1'b1);
        chk("R10 soft-start after release", soft_start, 1'b1);
        vcc_at_start = 0; tick(2);

        // R9 latch from normal run
        ext_latch = 1; tick(3);
        chk("R9 latch from run", sw_en, 1'b0);
        ext_latch = 0; vcc_at_start = 1; tick(3);
        chk("R8 start level alone does not release", sw_en, 1'b0);
        vcc_at_start = 0; tick(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule